// File: doc/BRIEF.md
# Byte-Handshake Packet Transfer Engine

This block moves packets of variable length, one byte at a time, between a host and a peripheral controller. The two sides share an 8-bit shift data register. Three control lines carry the handshake. The host drives a transaction line and an acknowledge line. The block drives a request line. All three lines are active low. A direction bit, written separately by the host, decides whether the host is sending or receiving. Bytes do not advance on a clock. A byte advances each time the host toggles one of its lines, and the block looks at the lines only in a cycle where the host writes them, writes the direction, or starts a new reply.

When the host sends, every line change during a transaction copies the shift register into an outbound buffer. When the transaction line returns high, the collected bytes are handed to a downstream command handler. When the host receives, every line change during a transaction loads the next byte of a reply buffer into the shift register. The reply buffer is filled by the command side. While no transaction is open, the block drives request low to ask the host to read a pending reply. An acknowledge toggle while idle is echoed on request as an attention handshake. Every step of the handshake raises a shift interrupt flag, which the host clears.

Top module: `hs_xfer_engine`

## Requirements
- R1: After reset, req_line is 1, sr_flag is 0, sr_data is 0 and pkt_done is 0.
- R2: With dir_send=1 and the transaction line low (0), any change of the acknowledge or transaction line from its previous level copies sr_data into the next outbound slot, in arrival order starting at slot 0, and sets sr_flag.
- R3: Once OUT_DEPTH bytes have been collected, further line changes store nothing and leave sr_flag unchanged.
- R4: A rise of the transaction line from 0 to 1 sets sr_flag. If at least one byte was collected, pkt_done is 1 for exactly one cycle, pkt_len shows the byte count, and the next packet starts again at slot 0. With no bytes collected, pkt_done stays 0.
- R5: With dir_send=0, the transaction line low and reply bytes remaining, any change of the lines loads the next reply byte (starting at address 0) into sr_data and sets sr_flag. Delivering the last byte drives req_line to 1, and req_line stays 0 before that.
- R6: With dir_send=0, the transaction line low and no reply bytes remaining, a line change leaves sr_data and sr_flag unchanged.
- R7: While the transaction line stays 1, a change of the acknowledge line copies its new level onto req_line and sets sr_flag.
- R8: When the transaction line is 1, no acknowledge change is seen and reply bytes remain, any evaluation (line write, direction write or reply start) drives req_line to 0.
- R9: A reply start (rpl_go) takes rpl_len as the new length, rewinds the read position to address 0 and sets sr_flag.
- R10: In a cycle with no line write, direction write or reply start, req_line is unchanged. sr_clr clears sr_flag, and sr_wr loads sr_data without touching req_line or sr_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Host writes the handshake lines this cycle |
| ctl_tip | input | 1 | Transaction line level (0 = transaction open) |
| ctl_ack | input | 1 | Acknowledge line level |
| dir_wr | input | 1 | Host writes the direction bit this cycle |
| dir_send | input | 1 | Direction: 1 = host sends, 0 = host receives |
| sr_wr | input | 1 | Host writes the shift register |
| sr_wdata | input | 8 | Shift register write data |
| sr_clr | input | 1 | Clears the shift interrupt flag |
| rpl_wr | input | 1 | Reply buffer write enable |
| rpl_waddr | input | IAW | Reply buffer write address |
| rpl_wdata | input | 8 | Reply buffer write data |
| rpl_go | input | 1 | Starts a new reply of rpl_len bytes |
| rpl_len | input | ICW | Reply length in bytes |
| pkt_raddr | input | OAW | Outbound buffer read address for the handler |
| req_line | output | 1 | Request line level driven by the block |
| sr_data | output | 8 | Shift register contents |
| sr_flag | output | 1 | Shift interrupt flag |
| pkt_done | output | 1 | One-cycle pulse: outbound packet complete |
| pkt_len | output | OCW | Byte count of the last completed packet |
| pkt_rdata | output | 8 | Outbound buffer read data |

## Verification
The bench builds the engine with OUT_DEPTH=4 and IN_DEPTH=8. With these values it can sweep every outbound packet length from one byte up to one more than the buffer holds, so the full-buffer refusal is reached on every run. It also sweeps every reply length from one to the full reply buffer. Expected reply bytes and packet lengths are computed from the sweep index. A reply is cut off mid-stream and then reloaded, which exercises the rewind of the read position and the request line being pulled low by a direction write.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // Action chosen by one handshake evaluation
  typedef enum logic [2:0] {
    HS_NONE  = 3'd0,
    HS_STORE = 3'd1,
    HS_FEED  = 3'd2,
    HS_ATTN  = 3'd3,
    HS_CLOSE = 3'd4,
    HS_IDLE  = 3'd5
  } hs_act_t;

  // Host-driven handshake lines, both active low
  typedef struct packed {
    logic tip;
    logic ack;
  } hs_lines_t;
endpackage

// File: rtl/hs_byte_buf.sv
module hs_byte_buf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
#(
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 128,
  localparam int OAW = $clog2(OUT_DEPTH),
  localparam int IAW = $clog2(IN_DEPTH),
  localparam int OCW = $clog2(OUT_DEPTH + 1),
  localparam int ICW = $clog2(IN_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_wr,
  input  logic           ctl_tip,
  input  logic           ctl_ack,
  input  logic           dir_wr,
  input  logic           dir_send,
  input  logic           sr_wr,
  input  logic [7:0]     sr_wdata,
  input  logic           sr_clr,
  input  logic           rpl_go,
  input  logic [ICW-1:0] rpl_len,
  input  logic [7:0]     ib_rdata,
  output logic [IAW-1:0] ib_raddr,
  output logic           ob_we,
  output logic [OAW-1:0] ob_waddr,
  output logic [7:0]     ob_wdata,
  output logic           req_q,
  output logic [7:0]     sr_q,
  output logic           flag_q,
  output logic           done_q,
  output logic [OCW-1:0] plen_q
);
  hs_lines_t      lines_q, lines_n;
  logic           dir_q, dir_n;
  logic [OCW-1:0] cnt_q, cnt_d;
  logic [ICW-1:0] idx_q, idx_n, idx_d;
  logic [ICW-1:0] len_q, len_n;
  logic           req_d, flag_d, done_d;
  logic [7:0]     sr_d;
  logic [OCW-1:0] plen_d;
  logic           eval, changed, pending, ack_moved;
  hs_act_t        act;

  // Values after this cycle's host writes take effect
  always_comb begin
    lines_n = ctl_wr ? '{tip: ctl_tip, ack: ctl_ack} : lines_q;
    dir_n   = dir_wr ? dir_send : dir_q;
    len_n   = rpl_go ? rpl_len : len_q;
    idx_n   = rpl_go ? '0 : idx_q;
    eval    = ctl_wr | dir_wr | rpl_go;
    changed   = (lines_n.tip != lines_q.tip) | (lines_n.ack != lines_q.ack);
    ack_moved = lines_n.ack != lines_q.ack;
    pending   = idx_n < len_n;
  end

  // Handshake decision
  always_comb begin
    act = HS_NONE;
    if (eval) begin
      if (!lines_n.tip) begin
        if (dir_n) begin
          if (changed && (cnt_q < OCW'(OUT_DEPTH))) act = HS_STORE;
        end else if (changed && pending) begin
          act = HS_FEED;
        end
      end else if (lines_q.tip && ack_moved) begin
        act = HS_ATTN;
      end else if (!lines_q.tip) begin
        act = HS_CLOSE;
      end else begin
        act = HS_IDLE;
      end
    end
  end

  assign ib_raddr = idx_n[IAW-1:0];
  assign ob_waddr = cnt_q[OAW-1:0];
  assign ob_wdata = sr_q;
  assign ob_we    = (act == HS_STORE);

  // Next-state
  always_comb begin
    cnt_d  = cnt_q;
    idx_d  = idx_n;
    req_d  = req_q;
    sr_d   = sr_wr ? sr_wdata : sr_q;
    flag_d = sr_clr ? 1'b0 : flag_q;
    done_d = 1'b0;
    plen_d = plen_q;
    unique case (act)
      HS_STORE: begin
        cnt_d  = cnt_q + OCW'(1);
        flag_d = 1'b1;
      end
      HS_FEED: begin
        sr_d   = ib_rdata;
        idx_d  = idx_n + ICW'(1);
        if ((idx_n + ICW'(1)) >= len_n) req_d = 1'b1;
        flag_d = 1'b1;
      end
      HS_ATTN: begin
        req_d  = lines_n.ack;
        flag_d = 1'b1;
      end
      HS_CLOSE: begin
        flag_d = 1'b1;
        if (cnt_q != '0) begin
          done_d = 1'b1;
          plen_d = cnt_q;
        end
        cnt_d = '0;
        if (pending) req_d = 1'b0;
      end
      HS_IDLE: begin
        if (pending) req_d = 1'b0;
      end
      default: ;
    endcase
    if (rpl_go) flag_d = 1'b1;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= '{tip: 1'b1, ack: 1'b1};
      dir_q   <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      len_q   <= '0;
      req_q   <= 1'b1;
      sr_q    <= '0;
      flag_q  <= 1'b0;
      done_q  <= 1'b0;
      plen_q  <= '0;
    end else begin
      lines_q <= lines_n;
      dir_q   <= dir_n;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      len_q   <= len_n;
      req_q   <= req_d;
      sr_q    <= sr_d;
      flag_q  <= flag_d;
      done_q  <= done_d;
      plen_q  <= plen_d;
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= OCW'(OUT_DEPTH));

  // R5
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= len_q);

  // R5
  last_byte_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != $past(idx_q) && idx_q == len_q && idx_q != '0) |-> req_q);

  // R4
  close_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == '0 && flag_q && plen_q != '0));

  // R10
  quiet_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr || dir_wr || rpl_go) |=> $stable(req_q));

  // R10
  quiet_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr || dir_wr || rpl_go) |=> ($stable(cnt_q) && $stable(idx_q)));
endmodule

// File: rtl/hs_xfer_engine.sv
module hs_xfer_engine #(
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 128,
  localparam int OAW = $clog2(OUT_DEPTH),
  localparam int IAW = $clog2(IN_DEPTH),
  localparam int OCW = $clog2(OUT_DEPTH + 1),
  localparam int ICW = $clog2(IN_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_wr,
  input  logic           ctl_tip,
  input  logic           ctl_ack,
  input  logic           dir_wr,
  input  logic           dir_send,
  input  logic           sr_wr,
  input  logic [7:0]     sr_wdata,
  input  logic           sr_clr,
  input  logic           rpl_wr,
  input  logic [IAW-1:0] rpl_waddr,
  input  logic [7:0]     rpl_wdata,
  input  logic           rpl_go,
  input  logic [ICW-1:0] rpl_len,
  input  logic [OAW-1:0] pkt_raddr,
  output logic           req_line,
  output logic [7:0]     sr_data,
  output logic           sr_flag,
  output logic           pkt_done,
  output logic [OCW-1:0] pkt_len,
  output logic [7:0]     pkt_rdata
);
  logic           ob_we;
  logic [OAW-1:0] ob_waddr;
  logic [7:0]     ob_wdata;
  logic [IAW-1:0] ib_raddr;
  logic [7:0]     ib_rdata;

  hs_ctrl #(.OUT_DEPTH(OUT_DEPTH), .IN_DEPTH(IN_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_tip(ctl_tip), .ctl_ack(ctl_ack),
    .dir_wr(dir_wr), .dir_send(dir_send),
    .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_clr(sr_clr),
    .rpl_go(rpl_go), .rpl_len(rpl_len),
    .ib_rdata(ib_rdata), .ib_raddr(ib_raddr),
    .ob_we(ob_we), .ob_waddr(ob_waddr), .ob_wdata(ob_wdata),
    .req_q(req_line), .sr_q(sr_data), .flag_q(sr_flag),
    .done_q(pkt_done), .plen_q(pkt_len)
  );

  hs_byte_buf #(.DEPTH(OUT_DEPTH)) u_outbuf (
    .clk(clk), .wr_en(ob_we), .wr_addr(ob_waddr), .wr_data(ob_wdata),
    .rd_addr(pkt_raddr), .rd_data(pkt_rdata)
  );

  hs_byte_buf #(.DEPTH(IN_DEPTH)) u_rplbuf (
    .clk(clk), .wr_en(rpl_wr), .wr_addr(rpl_waddr), .wr_data(rpl_wdata),
    .rd_addr(ib_raddr), .rd_data(ib_rdata)
  );
endmodule

// File: tb/hs_xfer_engine_test.sv
module hs_xfer_engine_test;
  localparam int OD = 4;
  localparam int ID = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_wr = 0, ctl_tip = 1, ctl_ack = 1, dir_wr = 0, dir_send = 0;
  logic sr_wr = 0, sr_clr = 0, rpl_wr = 0, rpl_go = 0;
  logic [7:0] sr_wdata = 0, rpl_wdata = 0;
  logic [2:0] rpl_waddr = 0;
  logic [3:0] rpl_len = 0;
  logic [1:0] pkt_raddr = 0;
  logic req_line, sr_flag, pkt_done;
  logic [7:0] sr_data, pkt_rdata;
  logic [2:0] pkt_len;
  int checks = 0, errors = 0;
  logic ack = 1'b1;

  hs_xfer_engine #(.OUT_DEPTH(OD), .IN_DEPTH(ID)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_tip(ctl_tip), .ctl_ack(ctl_ack),
    .dir_wr(dir_wr), .dir_send(dir_send), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .sr_clr(sr_clr), .rpl_wr(rpl_wr), .rpl_waddr(rpl_waddr), .rpl_wdata(rpl_wdata),
    .rpl_go(rpl_go), .rpl_len(rpl_len), .pkt_raddr(pkt_raddr), .req_line(req_line),
    .sr_data(sr_data), .sr_flag(sr_flag), .pkt_done(pkt_done), .pkt_len(pkt_len),
    .pkt_rdata(pkt_rdata)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] obyte(int n, int b);
    return 8'((n * 37) + (b * 11) + 5);
  endfunction
  function automatic logic [7:0] rbyte(int s, int i);
    return 8'((s * 16) + (i * 7) + 1);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic lines(logic t, logic a);
    @(negedge clk); ctl_tip = t; ctl_ack = a; ctl_wr = 1;
    @(negedge clk); ctl_wr = 0;
  endtask
  task automatic setdir(logic s);
    @(negedge clk); dir_send = s; dir_wr = 1;
    @(negedge clk); dir_wr = 0;
  endtask
  task automatic wsr(logic [7:0] v);
    @(negedge clk); sr_wdata = v; sr_wr = 1;
    @(negedge clk); sr_wr = 0;
  endtask
  task automatic clrf();
    @(negedge clk); sr_clr = 1;
    @(negedge clk); sr_clr = 0;
  endtask
  task automatic load_reply(int s, int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); rpl_waddr = 3'(i); rpl_wdata = rbyte(s, i); rpl_wr = 1;
    end
    @(negedge clk); rpl_wr = 0; rpl_len = 4'(len); rpl_go = 1;
    @(negedge clk); rpl_go = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 req", int'(req_line), 1);
    chk("R1 flag", int'(sr_flag), 0);
    chk("R1 sr", int'(sr_data), 0);
    chk("R1 done", int'(pkt_done), 0);

    // Outbound sweep over every length up to one past full
    setdir(1'b1);
    for (int n = 1; n <= OD + 1; n++) begin
      int kept;
      kept = (n < OD) ? n : OD;
      for (int b = 0; b < n; b++) begin
        wsr(obyte(n, b));
        clrf();
        if (b != 0) ack = ~ack;
        lines(1'b0, ack);
        if (b < OD) chk("R2 flag on store", int'(sr_flag), 1);
        else        chk("R3 flag when full", int'(sr_flag), 0);
      end
      clrf();
      lines(1'b1, ack);
      chk("R4 done pulse", int'(pkt_done), 1);
      chk("R4 length", int'(pkt_len), kept);
      chk("R4 flag", int'(sr_flag), 1);
      for (int k = 0; k < kept; k++) begin
        pkt_raddr = 2'(k);
        #1;
        chk("R2 stored byte", int'(pkt_rdata), int'(obyte(n, k)));
      end
      @(negedge clk);
      chk("R4 single pulse", int'(pkt_done), 0);
    end

    // Empty transaction in receive direction, nothing pending
    setdir(1'b0);
    clrf();
    lines(1'b0, ack);
    chk("R6 no flag", int'(sr_flag), 0);
    ack = ~ack;
    lines(1'b0, ack);
    chk("R6 no flag on toggle", int'(sr_flag), 0);
    chk("R6 sr kept", int'(sr_data), int'(obyte(OD + 1, OD)));
    lines(1'b1, ack);
    chk("R4 flag on empty close", int'(sr_flag), 1);
    chk("R4 no done when empty", int'(pkt_done), 0);

    // Reply sweep over every length
    for (int len = 1; len <= ID; len++) begin
      clrf();
      load_reply(len, len);
      chk("R8 req low on pending", int'(req_line), 0);
      chk("R9 flag on load", int'(sr_flag), 1);
      for (int b = 0; b < len; b++) begin
        clrf();
        if (b != 0) ack = ~ack;
        lines(1'b0, ack);
        chk("R5 byte", int'(sr_data), int'(rbyte(len, b)));
        chk("R5 flag", int'(sr_flag), 1);
        chk("R5 req", int'(req_line), (b == len - 1) ? 1 : 0);
      end
      clrf();
      ack = ~ack;
      lines(1'b0, ack);
      chk("R6 flag after last", int'(sr_flag), 0);
      chk("R6 sr after last", int'(sr_data), int'(rbyte(len, len - 1)));
      lines(1'b1, ack);
      chk("R4 no done on receive", int'(pkt_done), 0);
    end

    // Cut a reply short, attention, direction write, reload
    load_reply(3, ID);
    for (int b = 0; b < 3; b++) begin
      if (b != 0) ack = ~ack;
      lines(1'b0, ack);
    end
    lines(1'b1, ack);
    chk("R8 req low after cut", int'(req_line), 0);
    ack = 1'b1;
    lines(1'b1, 1'b0);
    lines(1'b1, ack);
    chk("R7 req follows ack", int'(req_line), 1);
    setdir(1'b0);
    chk("R8 dir write pulls req", int'(req_line), 0);
    clrf();
    load_reply(9, 2);
    chk("R9 flag on reload", int'(sr_flag), 1);
    lines(1'b0, ack);
    chk("R9 rewind to first", int'(sr_data), int'(rbyte(9, 0)));
    chk("R9 req mid", int'(req_line), 0);
    ack = ~ack;
    lines(1'b0, ack);
    chk("R9 second byte", int'(sr_data), int'(rbyte(9, 1)));
    lines(1'b1, ack);

    // Idle attention handshake with nothing pending
    for (int t = 0; t < 2; t++) begin
      clrf();
      ack = ~ack;
      lines(1'b1, ack);
      chk("R7 req level", int'(req_line), int'(ack));
      chk("R7 flag", int'(sr_flag), 1);
    end

    // Quiet cycles and plain shift register write
    clrf();
    repeat (3) @(negedge clk);
    chk("R10 req quiet", int'(req_line), int'(ack));
    chk("R10 flag quiet", int'(sr_flag), 0);
    wsr(8'hA5);
    chk("R10 sr write", int'(sr_data), 8'hA5);
    chk("R10 flag after sr write", int'(sr_flag), 0);
    chk("R10 req after sr write", int'(req_line), int'(ack));
    ack = ~ack;
    lines(1'b1, ack);
    clrf();
    chk("R10 clear", int'(sr_flag), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule